// File: doc/BRIEF.md
# Character Cell Fetch and Pixel Sequencer

This block serves one character cell of a 256x192 tile display at a time. A scanline engine hands it the cell's row, column and pixel line, together with the layout select bits, the table base registers, the text colour and the backdrop colour. The block then works out which video-memory bytes the cell needs: the name entry, the pattern byte and, in the coloured graphics layouts, the colour byte. It reads them one at a time over a simple request/response memory port. Once the bytes are in, it emits the cell's pixels as 4-bit colour indices, one per clock, each with a valid strobe.

The three select bits choose one of seven layouts. The two graphics layouts use 8-pixel cells. The 40-column text layout uses 6-pixel cells. The multicolour layout uses 4x4 blocks. Banked versions of the text and multicolour layouts pick one of three pattern banks for each third of the screen. Two bar layouts ignore memory altogether. In the 40-column layouts the block also emits the 8-pixel backdrop borders: before column 0 and after the last column. Sprites, sync timing and the colour palette belong to other blocks.

The sequencer has ten states, S_IDLE, S_LBORD, S_NAME_REQ, S_NAME_WAIT, S_PAT_REQ, S_PAT_WAIT, S_COL_REQ, S_COL_WAIT, S_DRAW and S_RBORD, with these transitions:
- S_IDLE leaves on `cell_start`.
  - It goes to S_LBORD for column 0 of a 40-column layout.
  - Otherwise it goes to S_NAME_REQ.
  - It goes straight to S_DRAW instead when the display is off or a bar layout is selected.
- S_LBORD moves on after 8 pixels, by the same rule.
- Each request state lasts one cycle and then enters its wait state.
- Each wait state advances when `mem_rvalid` arrives:
  - S_NAME_WAIT goes to S_PAT_REQ.
  - S_PAT_WAIT goes to S_COL_REQ in the graphics layouts, and to S_DRAW in all others.
  - S_COL_WAIT goes to S_DRAW.
- S_DRAW lasts 6 or 8 pixels. It then goes to S_RBORD after the last text column, and back to S_IDLE otherwise.
- S_RBORD returns to S_IDLE after 8 pixels.

Top module: `charcell_fetch`

## Requirements
- R1: Reset state. After reset, `busy`, `mem_req` and `pix_valid` are all 0.
- R2: Plain graphics layout (`mode_sel`=000). The block makes three reads:
  - the name at `{name_base, row*32+col}`;
  - the pattern at `{patt_reg[2:0], name, line}`;
  - the colour at `{color_reg, 1'b0, name[7:3]}`.

  It then emits 8 pixels, pattern bit 7 first. A set bit shows the colour byte's high nibble and a clear bit its low nibble.
- R3: Text layout (`mode_sel` bit0 set, bit2 clear). The block makes two reads and no colour read:
  - the name at `{name_base, row*40+col}`;
  - the pattern at `{patt_reg[2:0], name, line}`.

  It then emits 6 pixels from pattern bits 7..2: a set bit shows `fg_text` and a clear bit shows `backdrop`.
- R4: In every layout with `mode_sel` bit0 set, the sequence is padded with 8 `backdrop` pixels. The padding comes before the cell when the column is 0 and after it when the column is 39.
- R5: Split graphics layout (`mode_sel`=010). Let cn = `{row[4:3], name}`, a 10-bit number. The reads are:
  - the pattern at `{patt_reg[2], cn[9:8] & patt_reg[1:0], name, line}`;
  - the colour at `{color_reg[7], cn[9:3] & color_reg[6:0], name[2:0], line}`.

  Pixels follow the rule of R2.
- R6: Multicolour layout (`mode_sel`=100). The pattern read is at `{patt_reg[2:0], name, row[1:0], line[2]}`. It emits 8 pixels: the first 4 take the low nibble and the last 4 take the high nibble.
- R7: Transparency. Any colour chosen from memory or `fg_text` that equals 0 is replaced by `backdrop`.
- R8: Banked layouts. With `mode_sel`=011 the block behaves as R3, and with 110 it behaves as R6. In both, the pattern address is `{patt_reg[2], row[4:3] & patt_reg[1:0], name, low3}`, where low3 is the value R3 or R6 uses.
- R9: Bar layouts (`mode_sel`=101 or 111). The block makes no memory reads. It emits `fg_text` x4 then `backdrop` x2, and R4 still applies.
- R10: With `disp_en`=0 the block makes no memory reads. Every pixel is `backdrop`, with the cell width and borders of the layout.
- R11: Memory handshake.
  - `mem_req` is a one-cycle pulse, and no new request is issued before `mem_rvalid` returns.
  - The block tolerates any response latency.
  - `cell_start` is ignored while `busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Layout select: bit0 text, bit1 split/bank, bit2 multicolour |
| disp_en | input | 1 | Display enable; 0 forces backdrop |
| name_base | input | 4 | Name table base, address bits 13..10 |
| color_reg | input | 8 | Colour table base / mask register |
| patt_reg | input | 3 | Pattern table base / bank mask register |
| fg_text | input | 4 | Text colour |
| backdrop | input | 4 | Backdrop colour |
| cell_start | input | 1 | Start processing one cell (sampled when idle) |
| cell_row | input | 5 | Character row 0..23 |
| cell_col | input | 6 | Character column 0..31 or 0..39 |
| cell_line | input | 3 | Pixel line within the cell |
| busy | output | 1 | Sequencer is not idle |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 14 | Read address, valid with `mem_req` |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| pix_valid | output | 1 | Pixel strobe |
| pix_color | output | 4 | Pixel colour index |

## Verification
Some properties hold on every clock cycle, and the assertions watch those:
- a request never lasts two cycles;
- no fetch happens while the display is off or a bar layout is active;
- no colour read is made outside the graphics layouts;
- a zero pixel appears only when the backdrop itself is zero.

Other behaviour can only be shown by the bench's scenarios, which compare exact request addresses and pixel sequences with values worked out from the requirements:
- the address arithmetic of each layout, including bank and mask combinations;
- the pixel ordering and nibble order;
- border placement at columns 0 and 39;
- rejection of a start that arrives while the block is busy.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef enum logic [2:0] {
        LAY_GFX1,
        LAY_GFX2,
        LAY_MULTI,
        LAY_MULTIB,
        LAY_TEXT,
        LAY_TEXTB,
        LAY_BARS
    } layout_e;

    // 40-column layouts with 6-pixel cells and side borders
    function automatic logic lay_is_text(layout_e l);
        return l inside {LAY_TEXT, LAY_TEXTB, LAY_BARS};
    endfunction

    // layouts whose pattern bank follows the screen third
    function automatic logic lay_is_banked(layout_e l);
        return l inside {LAY_GFX2, LAY_MULTIB, LAY_TEXTB};
    endfunction

    function automatic logic lay_is_multi(layout_e l);
        return l inside {LAY_MULTI, LAY_MULTIB};
    endfunction

    function automatic logic lay_has_color(layout_e l);
        return l inside {LAY_GFX1, LAY_GFX2};
    endfunction

endpackage

// File: rtl/ccf_mode_decode.sv
module ccf_mode_decode
    import ccf_pkg::*;
(
    input  logic [2:0] mode_sel,
    output layout_e    lay
);
    // bit0 text, bit1 split/bank, bit2 multicolour
    always_comb begin
        if (mode_sel[0]) begin
            if (mode_sel[2])      lay = LAY_BARS;
            else if (mode_sel[1]) lay = LAY_TEXTB;
            else                  lay = LAY_TEXT;
        end else if (mode_sel[2]) begin
            lay = mode_sel[1] ? LAY_MULTIB : LAY_MULTI;
        end else begin
            lay = mode_sel[1] ? LAY_GFX2 : LAY_GFX1;
        end
    end
endmodule

// File: rtl/ccf_addr_gen.sv
module ccf_addr_gen
    import ccf_pkg::*;
#(
    parameter int TEXT_COLS = 40,
    parameter int GFX_COLS  = 32
) (
    input  layout_e     lay,
    input  logic [4:0]  row,
    input  logic [5:0]  col,
    input  logic [2:0]  line,
    input  logic [7:0]  name,
    input  logic [3:0]  name_base,
    input  logic [7:0]  color_reg,
    input  logic [2:0]  patt_reg,
    output logic [13:0] name_addr,
    output logic [13:0] patt_addr,
    output logic [13:0] color_addr
);
    localparam int IDX_W = 10;

    logic [IDX_W-1:0] cell_idx;
    logic [1:0]       third;
    logic [1:0]       bank;
    logic [2:0]       low3;
    logic [6:0]       cn_hi7;

    always_comb begin
        if (lay_is_text(lay))
            cell_idx = IDX_W'(row) * IDX_W'(TEXT_COLS) + IDX_W'(col);
        else
            cell_idx = IDX_W'(row) * IDX_W'(GFX_COLS) + IDX_W'(col);

        third  = row[4:3];
        bank   = third & patt_reg[1:0];
        low3   = lay_is_multi(lay) ? {row[1:0], line[2]} : line;
        cn_hi7 = {third, name[7:3]} & color_reg[6:0];

        name_addr = {name_base, cell_idx};

        if (lay_is_banked(lay))
            patt_addr = {patt_reg[2], bank, name, low3};
        else
            patt_addr = {patt_reg, name, low3};

        if (lay == LAY_GFX2)
            color_addr = {color_reg[7], cn_hi7, name[2:0], line};
        else
            color_addr = {color_reg, 1'b0, name[7:3]};
    end
endmodule

// File: rtl/ccf_pixel_pick.sv
module ccf_pixel_pick
    import ccf_pkg::*;
(
    input  layout_e    lay,
    input  logic       disp_off,
    input  logic [2:0] idx,
    input  logic [7:0] patt,
    input  logic [7:0] colr,
    input  logic [3:0] fg_text,
    input  logic [3:0] backdrop,
    output logic [3:0] color
);
    logic [3:0] raw;
    logic       bit_on;

    always_comb begin
        bit_on = patt[3'd7 - idx];
        unique case (lay)
            LAY_GFX1, LAY_GFX2:    raw = bit_on ? colr[7:4] : colr[3:0];
            LAY_TEXT, LAY_TEXTB:   raw = bit_on ? fg_text : backdrop;
            LAY_MULTI, LAY_MULTIB: raw = idx[2] ? patt[7:4] : patt[3:0];
            default:               raw = idx[2] ? backdrop : fg_text;
        endcase
        if (disp_off || raw == 4'h0) color = backdrop;
        else                         color = raw;
    end
endmodule

// File: rtl/charcell_fetch.sv
module charcell_fetch
    import ccf_pkg::*;
#(
    parameter int TEXT_COLS  = 40,
    parameter int GFX_COLS   = 32,
    parameter int BORDER_PIX = 8,
    parameter int CELL_PIX   = 8,
    parameter int TEXT_PIX   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  mode_sel,
    input  logic        disp_en,
    input  logic [3:0]  name_base,
    input  logic [7:0]  color_reg,
    input  logic [2:0]  patt_reg,
    input  logic [3:0]  fg_text,
    input  logic [3:0]  backdrop,
    input  logic        cell_start,
    input  logic [4:0]  cell_row,
    input  logic [5:0]  cell_col,
    input  logic [2:0]  cell_line,
    output logic        busy,
    output logic        mem_req,
    output logic [13:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [7:0]  mem_rdata,
    output logic        pix_valid,
    output logic [3:0]  pix_color
);
    localparam int MAXP  = (BORDER_PIX > CELL_PIX) ? BORDER_PIX : CELL_PIX;
    localparam int CNT_W = $clog2(MAXP);

    typedef enum logic [3:0] {
        S_IDLE, S_LBORD, S_NAME_REQ, S_NAME_WAIT, S_PAT_REQ, S_PAT_WAIT,
        S_COL_REQ, S_COL_WAIT, S_DRAW, S_RBORD
    } state_e;

    state_e             state, state_nx;
    layout_e            lay_in, lay_q;
    logic               off_q;
    logic [4:0]         row_q;
    logic [5:0]         col_q;
    logic [2:0]         line_q;
    logic [3:0]         nb_q, tc_q, bd_q;
    logic [7:0]         cr_q, name_q, patt_q, colr_q;
    logic [2:0]         pr_q;
    logic [CNT_W-1:0]   cnt;
    logic [13:0]        a_name, a_patt, a_colr;
    logic [3:0]         pick_color;
    logic               last_pix, last_bord, last_col;

    function automatic state_e work_state(layout_e l, logic off);
        return (off || l == LAY_BARS) ? S_DRAW : S_NAME_REQ;
    endfunction

    ccf_mode_decode u_dec (.mode_sel(mode_sel), .lay(lay_in));

    ccf_addr_gen #(.TEXT_COLS(TEXT_COLS), .GFX_COLS(GFX_COLS)) u_addr (
        .lay(lay_q), .row(row_q), .col(col_q), .line(line_q), .name(name_q),
        .name_base(nb_q), .color_reg(cr_q), .patt_reg(pr_q),
        .name_addr(a_name), .patt_addr(a_patt), .color_addr(a_colr)
    );

    ccf_pixel_pick u_pick (
        .lay(lay_q), .disp_off(off_q), .idx(3'(cnt)), .patt(patt_q),
        .colr(colr_q), .fg_text(tc_q), .backdrop(bd_q), .color(pick_color)
    );

    assign last_bord = (cnt == CNT_W'(BORDER_PIX - 1));
    assign last_pix  = lay_is_text(lay_q) ? (cnt == CNT_W'(TEXT_PIX - 1))
                                          : (cnt == CNT_W'(CELL_PIX - 1));
    assign last_col  = lay_is_text(lay_q) && (col_q == 6'(TEXT_COLS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:
                if (cell_start)
                    state_nx = (lay_is_text(lay_in) && cell_col == 6'd0) ? S_LBORD
                             : work_state(lay_in, !disp_en);
            S_LBORD:     if (last_bord)  state_nx = work_state(lay_q, off_q);
            S_NAME_REQ:                  state_nx = S_NAME_WAIT;
            S_NAME_WAIT: if (mem_rvalid) state_nx = S_PAT_REQ;
            S_PAT_REQ:                   state_nx = S_PAT_WAIT;
            S_PAT_WAIT:  if (mem_rvalid) state_nx = lay_has_color(lay_q) ? S_COL_REQ : S_DRAW;
            S_COL_REQ:                   state_nx = S_COL_WAIT;
            S_COL_WAIT:  if (mem_rvalid) state_nx = S_DRAW;
            S_DRAW:      if (last_pix)   state_nx = last_col ? S_RBORD : S_IDLE;
            S_RBORD:     if (last_bord)  state_nx = S_IDLE;
            default:                     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = 14'd0;
        pix_valid = 1'b0;
        pix_color = 4'd0;
        busy      = (state != S_IDLE);
        unique case (state)
            S_NAME_REQ: begin mem_req = 1'b1; mem_addr = a_name; end
            S_PAT_REQ:  begin mem_req = 1'b1; mem_addr = a_patt; end
            S_COL_REQ:  begin mem_req = 1'b1; mem_addr = a_colr; end
            S_LBORD, S_RBORD: begin pix_valid = 1'b1; pix_color = bd_q; end
            S_DRAW:     begin pix_valid = 1'b1; pix_color = pick_color; end
            default: ;
        endcase
    end

    // datapath: cell context, fetched bytes, pixel counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lay_q <= LAY_GFX1; off_q <= 1'b0; row_q <= '0; col_q <= '0;
            line_q <= '0; nb_q <= '0; cr_q <= '0; pr_q <= '0; tc_q <= '0;
            bd_q <= '0; name_q <= '0; patt_q <= '0; colr_q <= '0; cnt <= '0;
        end else begin
            if (state == S_IDLE && cell_start) begin
                lay_q <= lay_in;    off_q <= !disp_en;
                row_q <= cell_row;  col_q <= cell_col;  line_q <= cell_line;
                nb_q <= name_base;  cr_q <= color_reg;  pr_q <= patt_reg;
                tc_q <= fg_text;    bd_q <= backdrop;
            end
            if (mem_rvalid) begin
                if (state == S_NAME_WAIT) name_q <= mem_rdata;
                if (state == S_PAT_WAIT)  patt_q <= mem_rdata;
                if (state == S_COL_WAIT)  colr_q <= mem_rdata;
            end
            if (state != state_nx) cnt <= '0;
            else if (pix_valid)    cnt <= cnt + 1'b1;
        end
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R11
    AST_OFF_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && off_q) |-> !mem_req); // R10
    AST_BARS_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lay_q == LAY_BARS) |-> !mem_req); // R9
    AST_TEXT_NO_COLOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COL_REQ) |-> lay_has_color(lay_q)); // R3
    AST_ZERO_ONLY_BACKDROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_color == 4'h0) |-> (bd_q == 4'h0)); // R7

endmodule

// File: tb/charcell_fetch_tb.sv
`timescale 1ns/1ps
module charcell_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic        disp_en = 1'b1;
    logic [3:0]  name_base = '0;
    logic [7:0]  color_reg = '0;
    logic [2:0]  patt_reg = '0;
    logic [3:0]  fg_text = '0;
    logic [3:0]  backdrop = '0;
    logic        cell_start = 1'b0;
    logic [4:0]  cell_row = '0;
    logic [5:0]  cell_col = '0;
    logic [2:0]  cell_line = '0;
    logic        busy, mem_req, pix_valid;
    logic [13:0] mem_addr;
    logic [3:0]  pix_color;
    logic        mem_rvalid;
    logic [7:0]  mem_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // memory model
    logic [7:0]  resp [3];
    logic [13:0] addr_log [64];
    logic [3:0]  pix_log [256];
    logic [3:0]  vpipe = '0;
    int          lat = 1;
    int          req_cnt = 0, req_base = 0;
    int          pix_cnt = 0, pix_base = 0;
    int          nreq, npx;

    always #10 clk = ~clk;

    assign mem_rvalid = vpipe[lat-1];

    always @(posedge clk) begin
        vpipe <= {vpipe[2:0], mem_req};
        if (mem_req) begin
            addr_log[req_cnt % 64] <= mem_addr;
            mem_rdata <= resp[(req_cnt - req_base) % 3];
            req_cnt   <= req_cnt + 1;
        end
        if (pix_valid) begin
            pix_log[pix_cnt % 256] <= pix_color;
            pix_cnt <= pix_cnt + 1;
        end
    end

    charcell_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .disp_en(disp_en),
        .name_base(name_base), .color_reg(color_reg), .patt_reg(patt_reg),
        .fg_text(fg_text), .backdrop(backdrop), .cell_start(cell_start),
        .cell_row(cell_row), .cell_col(cell_col), .cell_line(cell_line),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_color(pix_color)
    );

    task automatic chk(input string r, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    function automatic int req_at(int i);
        return int'(addr_log[(req_base + i) % 64]);
    endfunction

    function automatic int pix_at(int i);
        return int'(pix_log[(pix_base + i) % 256]);
    endfunction

    function automatic int tr(int c);
        return (c == 0) ? int'(backdrop) : c;
    endfunction

    task automatic run_cell(input logic [2:0] md, input logic en, input int row,
                            input int col, input int line,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        int n;
        @(negedge clk);
        resp[0] = d0; resp[1] = d1; resp[2] = d2;
        req_base = req_cnt; pix_base = pix_cnt;
        mode_sel = md; disp_en = en;
        cell_row = 5'(row); cell_col = 6'(col); cell_line = 3'(line);
        cell_start = 1'b1;
        @(negedge clk);
        cell_start = 1'b0;
        n = 0;
        while (busy && n < 300) begin @(negedge clk); n++; end
        if (n >= 300) chk("R11", "cell timeout", 1, 0);
        nreq = req_cnt - req_base;
        npx  = pix_cnt - pix_base;
    endtask

    task automatic test_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "mem_req", mem_req, 0);
        chk("R1", "pix_valid", pix_valid, 0);
    endtask

    task automatic test_gfx1();
        logic [7:0] nm = 8'hA3, pt = 8'hB2, cl = 8'h49;
        name_base = 4'h2; patt_reg = 3'b011; color_reg = 8'h5C; backdrop = 4'hE;
        lat = 1;
        run_cell(3'b000, 1'b1, 5, 7, 3, nm, pt, cl);
        chk("R2", "req count", nreq, 3);
        chk("R2", "name addr", req_at(0), (2 << 10) | (5*32 + 7));
        chk("R2", "patt addr", req_at(1), (3 << 11) | (int'(nm) << 3) | 3);
        chk("R2", "color addr", req_at(2), (8'h5C << 6) | (int'(nm) >> 3));
        chk("R2", "pixel count", npx, 8);
        for (int i = 0; i < 8; i++)
            chk("R2", "pixel", pix_at(i), pt[7-i] ? tr(cl[7:4]) : tr(cl[3:0]));
    endtask

    task automatic test_transparent();
        logic [7:0] pt = 8'hF0, cl = 8'h07;
        backdrop = 4'hE; lat = 3;
        run_cell(3'b000, 1'b1, 1, 1, 0, 8'h10, pt, cl);
        for (int i = 0; i < 8; i++)
            chk("R7", "pixel", pix_at(i), (i < 4) ? 4'hE : 4'h7);
    endtask

    task automatic gfx2_case(input int row, input logic [2:0] pr, input logic [7:0] cr);
        logic [7:0] nm = 8'h5A, pt = 8'h3C, cl = 8'h2F;
        int cn, line;
        line = 5;
        patt_reg = pr; color_reg = cr; name_base = 4'h3; backdrop = 4'h4; lat = 2;
        run_cell(3'b010, 1'b1, row, 3, line, nm, pt, cl);
        cn = ((row / 8) << 8) | int'(nm);
        chk("R5", "req count", nreq, 3);
        chk("R5", "patt addr", req_at(1),
            (int'(pr[2]) << 13) | ((cn & ((int'(pr[1:0]) << 8) | 8'hFF)) << 3) | line);
        chk("R5", "color addr", req_at(2),
            (int'(cr[7]) << 13) | ((cn & ((int'(cr[6:0]) << 3) | 7)) << 3) | line);
        for (int i = 0; i < 8; i++)
            chk("R5", "pixel", pix_at(i), pt[7-i] ? tr(cl[7:4]) : tr(cl[3:0]));
    endtask

    task automatic test_gfx2();
        gfx2_case(13, 3'b101, 8'h83);
        gfx2_case(20, 3'b110, 8'hFF);
        gfx2_case(20, 3'b001, 8'h00);
    endtask

    task automatic test_text();
        logic [7:0] nm = 8'h41, pt = 8'hA7;
        name_base = 4'h1; patt_reg = 3'b100; fg_text = 4'hF; backdrop = 4'h1; lat = 1;
        run_cell(3'b001, 1'b1, 2, 5, 6, nm, pt, 8'h00);
        chk("R3", "req count", nreq, 2);
        chk("R3", "name addr", req_at(0), (1 << 10) | (2*40 + 5));
        chk("R3", "patt addr", req_at(1), (4 << 11) | (int'(nm) << 3) | 6);
        chk("R3", "pixel count", npx, 6);
        for (int i = 0; i < 6; i++)
            chk("R3", "pixel", pix_at(i), pt[7-i] ? 4'hF : 4'h1);
    endtask

    task automatic test_borders();
        logic [7:0] pt = 8'hFC;
        fg_text = 4'h0; backdrop = 4'h6; name_base = 4'h0; lat = 2;
        // left border, text colour 0 also becomes backdrop (R7)
        run_cell(3'b001, 1'b1, 0, 0, 0, 8'h01, pt, 8'h00);
        chk("R4", "left pixel count", npx, 14);
        for (int i = 0; i < 14; i++) chk("R4", "left pixel", pix_at(i), 4'h6);
        fg_text = 4'hA;
        run_cell(3'b001, 1'b1, 23, 39, 0, 8'h01, pt, 8'h00);
        chk("R4", "name addr last cell", req_at(0), 23*40 + 39);
        chk("R4", "right pixel count", npx, 14);
        for (int i = 0; i < 6; i++)  chk("R4", "cell pixel", pix_at(i), 4'hA);
        for (int i = 6; i < 14; i++) chk("R4", "right pixel", pix_at(i), 4'h6);
    endtask

    task automatic test_multi();
        logic [7:0] nm = 8'h21;
        patt_reg = 3'b010; backdrop = 4'h9; lat = 1;
        run_cell(3'b100, 1'b1, 6, 4, 5, nm, 8'h7C, 8'h00);
        chk("R6", "req count", nreq, 2);
        chk("R6", "patt addr", req_at(1), (2 << 11) | (int'(nm) << 3) | (2*2 + 1));
        for (int i = 0; i < 8; i++) chk("R6", "pixel", pix_at(i), (i < 4) ? 4'hC : 4'h7);
        run_cell(3'b100, 1'b1, 0, 0, 0, nm, 8'h03, 8'h00);
        for (int i = 0; i < 8; i++) chk("R7", "multi pixel", pix_at(i), (i < 4) ? 4'h3 : 4'h9);
    endtask

    task automatic test_banked();
        logic [7:0] nm = 8'h66, pt = 8'hC3;
        patt_reg = 3'b110; fg_text = 4'h2; backdrop = 4'h5; lat = 1;
        run_cell(3'b011, 1'b1, 18, 9, 4, nm, pt, 8'h00);
        chk("R8", "text req count", nreq, 2);
        chk("R8", "text patt addr", req_at(1), (1 << 13) | (2 << 11) | (int'(nm) << 3) | 4);
        for (int i = 0; i < 6; i++) chk("R8", "text pixel", pix_at(i), pt[7-i] ? 4'h2 : 4'h5);
        patt_reg = 3'b001;
        run_cell(3'b110, 1'b1, 9, 2, 7, nm, 8'hB0, 8'h00);
        chk("R8", "multi patt addr", req_at(1), (1 << 11) | (int'(nm) << 3) | (1*2 + 1));
        for (int i = 0; i < 8; i++) chk("R8", "multi pixel", pix_at(i), (i < 4) ? 4'h5 : 4'hB);
    endtask

    task automatic test_bars();
        fg_text = 4'hD; backdrop = 4'h3;
        run_cell(3'b101, 1'b1, 4, 10, 2, 8'h11, 8'h22, 8'h33);
        chk("R9", "req count", nreq, 0);
        chk("R9", "pixel count", npx, 6);
        for (int i = 0; i < 6; i++) chk("R9", "pixel", pix_at(i), (i < 4) ? 4'hD : 4'h3);
        run_cell(3'b111, 1'b1, 4, 39, 2, 8'h11, 8'h22, 8'h33);
        chk("R9", "req count 111", nreq, 0);
        chk("R9", "pixel count 111", npx, 14);
        for (int i = 0; i < 14; i++)
            chk("R9", "pixel 111", pix_at(i), (i < 4) ? 4'hD : 4'h3);
    endtask

    task automatic test_blank();
        backdrop = 4'h8; fg_text = 4'hF;
        run_cell(3'b000, 1'b0, 3, 3, 3, 8'hFF, 8'hFF, 8'hFF);
        chk("R10", "req count", nreq, 0);
        chk("R10", "pixel count", npx, 8);
        for (int i = 0; i < 8; i++) chk("R10", "pixel", pix_at(i), 4'h8);
        run_cell(3'b001, 1'b0, 0, 0, 0, 8'hFF, 8'hFF, 8'hFF);
        chk("R10", "text req count", nreq, 0);
        chk("R10", "text pixel count", npx, 14);
        for (int i = 0; i < 14; i++) chk("R10", "text pixel", pix_at(i), 4'h8);
    endtask

    task automatic test_busy_ignore();
        int n, rc;
        @(negedge clk);
        resp[0] = 8'h01; resp[1] = 8'hFF; resp[2] = 8'h12;
        req_base = req_cnt; pix_base = pix_cnt; lat = 4;
        mode_sel = 3'b000; disp_en = 1'b1; backdrop = 4'h7;
        cell_row = 5'd1; cell_col = 6'd1; cell_line = 3'd1;
        cell_start = 1'b1;
        @(negedge clk);
        cell_start = 1'b0;
        repeat (2) @(negedge clk);
        cell_col = 6'd0; mode_sel = 3'b001; cell_start = 1'b1;
        @(negedge clk);
        cell_start = 1'b0;
        n = 0;
        while (busy && n < 300) begin @(negedge clk); n++; end
        chk("R11", "req count", req_cnt - req_base, 3);
        chk("R11", "pixel count", pix_cnt - pix_base, 8);
        for (int i = 0; i < 8; i++) chk("R11", "pixel", pix_at(i), 4'h1);
        rc = req_cnt;
        repeat (10) @(negedge clk);
        chk("R11", "stays idle", busy, 0);
        chk("R11", "no late req", req_cnt - rc, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_gfx1();
        test_transparent();
        test_gfx2();
        test_text();
        test_borders();
        test_multi();
        test_banked();
        test_bars();
        test_blank();
        test_busy_ignore();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule